// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache placed between a word-addressed processor port and a slower memory port. The memory port transfers data one word per handshake, always as a full line of four words. The cache holds a number of sets. Each set has two ways, and each way keeps a tag, a valid flag, a dirty flag and a four-word line. On every request, both ways of the addressed set are read and their tags are compared side by side. When one way matches, its word is returned in the same cycle, or the write updates that word in place.

On a miss, the processor port reports busy, and a small sequencer takes over. It picks the victim way from a single least-recently-used bit kept for the set. If the victim line holds modified data, the sequencer first copies it out to memory. It then fetches the four words of the requested line. When the refill has finished, the request that was held is replayed and completes as a hit. Modified data leaves the cache only when its line is evicted.

Top module: `sa2_wb_cache`

## Requirements
- R1: The word address splits into a word offset in bits [1:0], a set index in bits [3:2] (with the default four sets), and a tag in all remaining upper bits.
- R2: A request hits when a way of the indexed set is valid and holds the request tag. In that case `busy` is low in the same cycle, and a read returns the addressed word of that way on `rsp_rdata`.
- R3: While a request is held and no way hits, `busy` stays high. Once the refill is complete, the same request completes as a hit.
- R4: A refill issues four memory reads (`mem_we`=0) at the line base address {tag, index, 00}, with offsets 0, 1, 2 and 3 in that order.
- R5: Each set has one LRU bit. Every hit and every refill sets it to the way that was not used, and a miss evicts the way that the bit selects.
- R6: A write hit stores the word in place, generates no memory traffic, and marks the line dirty.
- R7: A dirty victim is written to memory before any refill read. These are four writes at {victim tag, index, offset}, offsets 0 to 3 in order, carrying the line's current data.
- R8: A victim that is clean or invalid is dropped without any memory write.
- R9: A write miss first refills the line and then performs the write as a hit. The line therefore becomes dirty, and the other three words are the values fetched from memory.
- R10: Reset clears all valid, dirty and LRU bits. After reset, `busy` and `mem_req` are low, and the first access to any address misses.
- R11: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present; held until busy is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| rsp_rdata | output | DATA_W | Read word of the hitting way |
| busy | output | 1 | Request not finishing this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | ADDR_W | Word address of the beat |
| mem_wdata | output | DATA_W | Write-back word |
| mem_rdata | input | DATA_W | Refill word, valid with mem_ack |
| mem_ack | input | 1 | Beat accepted or completed this cycle |

## Verification
Directed sequences are aimed at one set. One of them fills both ways and touches one of them before forcing a third tag in; it separates a correct LRU choice from a fixed-way or a most-recently-used choice. Another writes into a line and then evicts it, which shows whether a write-back happens at all, whether it comes before the refill, and which address and data it carries. The bench also issues random reads and writes over a few tags that share sets. The memory answers after random delays, so the order and content of every memory beat can be compared with a reference model. That comparison tells a hit from a miss, a clean eviction from a dirty one, and a correct index or tag split from a wrong one.

// File: rtl/sa2_cache_pkg.sv
package sa2_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sa2_cache_way.sv
module sa2_cache_way #(
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic [TAG_W-1:0]  cmp_tag,
  output logic              way_hit,
  output logic [DATA_W-1:0] way_word,
  output logic [TAG_W-1:0]  way_tag,
  output logic              way_valid,
  output logic              way_dirty,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [OFF_W-1:0]  wb_off,
  output logic [DATA_W-1:0] wb_word,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              fill_wr,
  input  logic              fill_done,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);
  logic [DATA_W-1:0] data_q [SETS][WORDS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;

  assign way_tag   = tag_q[rd_idx];
  assign way_valid = valid_q[rd_idx];
  assign way_dirty = dirty_q[rd_idx];
  assign way_hit   = valid_q[rd_idx] && (tag_q[rd_idx] == cmp_tag);
  assign way_word  = data_q[rd_idx][rd_off];
  assign wb_word   = data_q[wb_idx][wb_off];

  always_ff @(posedge clk) begin
    if (fill_wr) data_q[wb_idx][wb_off] <= fill_data;
    else if (cpu_wr) data_q[rd_idx][rd_off] <= cpu_wdata;
    if (fill_done) tag_q[wb_idx] <= fill_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_done) begin
      valid_q[wb_idx] <= 1'b1;
      dirty_q[wb_idx] <= 1'b0;
    end else if (cpu_wr) begin
      dirty_q[rd_idx] <= 1'b1;
    end
  end

  p_write_marks_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> dirty_q[$past(rd_idx)]);
  p_fill_validates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (valid_q[$past(wb_idx)] && !dirty_q[$past(wb_idx)]));
endmodule

// File: rtl/sa2_cache_lru.sv
module sa2_cache_lru #(
  parameter int SETS = 4,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  output logic             victim_way,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way
);
  logic [SETS-1:0] lru_q;

  assign victim_way = lru_q[look_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else if (touch_en) lru_q[touch_idx] <= ~touch_way;
  end

  p_lru_points_away_r5: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (lru_q[$past(touch_idx)] != $past(touch_way)));
endmodule

// File: rtl/sa2_cache_seq.sv
module sa2_cache_seq
  import sa2_cache_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WORDS = 4,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS),
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              any_hit,
  input  logic              lru_way,
  input  logic [TAG_W-1:0]  victim_tag,
  input  logic              victim_dirty,
  input  logic              mem_ack,
  output logic              idle,
  output logic              miss_start,
  output logic              fill_wr,
  output logic              fill_done,
  output logic              vic_way,
  output logic [IDX_W-1:0]  line_idx,
  output logic [OFF_W-1:0]  beat,
  output logic [TAG_W-1:0]  line_tag,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

  seq_state_t st_q;
  logic [TAG_W-1:0] vtag_q;
  logic             wb_done;

  function automatic logic [ADDR_W-1:0] f_beat_addr(input logic [TAG_W-1:0] t,
      input logic [IDX_W-1:0] i, input logic [OFF_W-1:0] o);
    return {t, i, o};
  endfunction

  assign idle       = (st_q == ST_IDLE);
  assign miss_start = idle && req_valid && !any_hit;
  assign fill_wr    = (st_q == ST_FILL) && mem_ack;
  assign fill_done  = fill_wr && (beat == LAST_BEAT);
  assign wb_done    = (st_q == ST_WBACK) && mem_ack && (beat == LAST_BEAT);
  assign mem_req    = !idle;
  assign mem_we     = (st_q == ST_WBACK);
  assign mem_addr   = f_beat_addr(mem_we ? vtag_q : line_tag, line_idx, beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      beat     <= '0;
      vic_way  <= 1'b0;
      line_idx <= '0;
      line_tag <= '0;
      vtag_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (miss_start) begin
          line_idx <= req_idx;
          line_tag <= req_tag;
          vic_way  <= lru_way;
          vtag_q   <= victim_tag;
          beat     <= '0;
          st_q     <= victim_dirty ? ST_WBACK : ST_FILL;
        end
        ST_WBACK: if (mem_ack) begin
          beat <= beat + 1'b1;
          if (beat == LAST_BEAT) st_q <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          beat <= beat + 1'b1;
          if (beat == LAST_BEAT) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_wback_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> (st_q == ST_FILL && beat == '0));
  p_clean_victim_skips_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_start && !victim_dirty) |=> (st_q == ST_FILL && !mem_we));
  p_hold_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_fill_ends_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> idle);
endmodule

// File: rtl/sa2_wb_cache.sv
module sa2_wb_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int WAYS  = 2;
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  logic [WAYS-1:0]   way_hit, way_valid, way_dirty;
  logic [DATA_W-1:0] way_word [WAYS];
  logic [DATA_W-1:0] wb_word  [WAYS];
  logic [TAG_W-1:0]  way_tag  [WAYS];
  logic              any_hit, hit_way, lru_way, idle, miss_start;
  logic              fill_wr, fill_done, vic_way, accept_hit;
  logic [IDX_W-1:0]  line_idx;
  logic [OFF_W-1:0]  beat;
  logic [TAG_W-1:0]  line_tag;

  assign any_hit    = |way_hit;
  assign hit_way    = way_hit[1];
  assign accept_hit = idle && req_valid && any_hit;
  assign busy       = req_valid && !accept_hit;
  assign rsp_rdata  = way_word[hit_way];
  assign mem_wdata  = wb_word[vic_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    sa2_cache_way #(.DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W)) u_way (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (f_idx(req_addr)),
      .rd_off    (f_off(req_addr)),
      .cmp_tag   (f_tag(req_addr)),
      .way_hit   (way_hit[w]),
      .way_word  (way_word[w]),
      .way_tag   (way_tag[w]),
      .way_valid (way_valid[w]),
      .way_dirty (way_dirty[w]),
      .wb_idx    (line_idx),
      .wb_off    (beat),
      .wb_word   (wb_word[w]),
      .cpu_wr    (accept_hit && req_we && way_hit[w]),
      .cpu_wdata (req_wdata),
      .fill_wr   (fill_wr && (vic_way == 1'(w))),
      .fill_done (fill_done && (vic_way == 1'(w))),
      .fill_tag  (line_tag),
      .fill_data (mem_rdata)
    );
  end

  sa2_cache_lru #(.SETS(SETS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_idx   (f_idx(req_addr)),
    .victim_way (lru_way),
    .touch_en   (accept_hit || fill_done),
    .touch_idx  (fill_done ? line_idx : f_idx(req_addr)),
    .touch_way  (fill_done ? vic_way : hit_way)
  );

  sa2_cache_seq #(.SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_idx      (f_idx(req_addr)),
    .req_tag      (f_tag(req_addr)),
    .any_hit      (any_hit),
    .lru_way      (lru_way),
    .victim_tag   (way_tag[lru_way]),
    .victim_dirty (way_valid[lru_way] && way_dirty[lru_way]),
    .mem_ack      (mem_ack),
    .idle         (idle),
    .miss_start   (miss_start),
    .fill_wr      (fill_wr),
    .fill_done    (fill_done),
    .vic_way      (vic_way),
    .line_idx     (line_idx),
    .beat         (beat),
    .line_tag     (line_tag),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr)
  );

  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));
  p_miss_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_start |=> !idle);
  p_write_hit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_hit && req_we) |-> !mem_req);
endmodule

// File: tb/sa2_wb_cache_bench.sv
module sa2_wb_cache_bench;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata;
  logic          busy, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;

  always #10 clk = ~clk;

  sa2_wb_cache #(.ADDR_W(AW), .DATA_W(DW)) u_sa2_wb_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] ref_mem [256];
  logic          rv [2][4];
  logic          rdy [2][4];
  logic [3:0]    rt [2][4];
  logic          rl [4];
  logic [DW-1:0] rdat [2][4][4];

  logic [40:0] log_e [16];
  int          log_n = 0;
  logic [40:0] exp_e [8];
  int          exp_n;

  logic          pend = 1'b0;
  logic [AW-1:0] pend_addr = '0;
  logic          pend_we = 1'b0;

  function automatic logic [DW-1:0] init_word(input int a);
    return (32'(a) * 32'h0101_0101) ^ 32'hA5A5_0000;
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory model: random-delay beats, logs every accepted beat
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        chk("R11 req held", {63'd0, mem_req}, 64'd1);
        chk("R11 beat stable", {55'd0, mem_we, mem_addr}, {55'd0, pend_we, pend_addr});
      end
      mem_ack = mem_req && ($urandom_range(0, 2) != 0);
      if (mem_ack) begin
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = mem[mem_addr];
        if (log_n < 16) log_e[log_n] = {mem_we, mem_addr, mem_we ? mem_wdata : mem[mem_addr]};
        log_n++;
      end
      pend = mem_req && !mem_ack;
      pend_addr = mem_addr;
      pend_we = mem_we;
    end
  end

  task automatic do_access(input logic we, input logic [7:0] a, input logic [DW-1:0] wd);
    logic [1:0] ix, of, vw;
    logic [3:0] tg;
    int hw;
    logic miss;
    logic [DW-1:0] exp_rd;
    ix = a[3:2]; of = a[1:0]; tg = a[7:4];
    hw = -1;
    for (int w = 0; w < 2; w++) if (rv[w][ix] && rt[w][ix] == tg) hw = w;
    miss = (hw < 0);
    exp_n = 0;
    if (miss) begin
      vw = {1'b0, rl[ix]};
      if (rv[vw[0]][ix] && rdy[vw[0]][ix])
        for (int b = 0; b < 4; b++) begin
          exp_e[exp_n] = {1'b1, rt[vw[0]][ix], ix, 2'(b), rdat[vw[0]][ix][b]};
          ref_mem[{rt[vw[0]][ix], ix, 2'(b)}] = rdat[vw[0]][ix][b];
          exp_n++;
        end
      for (int b = 0; b < 4; b++) begin
        exp_e[exp_n] = {1'b0, tg, ix, 2'(b), ref_mem[{tg, ix, 2'(b)}]};
        rdat[vw[0]][ix][b] = ref_mem[{tg, ix, 2'(b)}];
        exp_n++;
      end
      rv[vw[0]][ix] = 1'b1; rt[vw[0]][ix] = tg; rdy[vw[0]][ix] = 1'b0;
      hw = int'(vw[0]);
    end
    exp_rd = rdat[hw][ix][of];
    if (we) begin
      rdat[hw][ix][of] = wd;
      rdy[hw][ix] = 1'b1;
    end
    rl[ix] = (hw == 0);
    log_n = 0;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    #5;
    chk(miss ? "R3 busy on miss" : "R2 busy low on hit", {63'd0, busy}, {63'd0, miss});
    while (busy) begin
      @(negedge clk); #5;
    end
    if (!we) chk("R2/R1 read word", {32'd0, rsp_rdata}, {32'd0, exp_rd});
    chk("R4/R7/R8 beat count", 64'(log_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++)
      chk(exp_e[i][40] ? "R7/R5 write-back beat" : "R4/R9 refill beat",
          {23'd0, log_e[i]}, {23'd0, exp_e[i]});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_word(i);
      ref_mem[i] = init_word(i);
    end
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++) begin
        rv[w][s] = 1'b0; rdy[w][s] = 1'b0; rt[w][s] = '0;
        rl[s] = 1'b0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R10 busy after reset", {63'd0, busy}, 64'd0);
    chk("R10 mem_req after reset", {63'd0, mem_req}, 64'd0);
    @(negedge clk);
    // directed: R10 first miss, R5 LRU choice, R6 write hit, R7 dirty evict, R9 write miss
    do_access(1'b0, 8'h00, '0);  // R10 cold miss
    do_access(1'b0, 8'h10, '0);  // second way of set 0
    do_access(1'b0, 8'h01, '0);  // R2 hit, R5 touches tag 0
    do_access(1'b0, 8'h23, '0);  // R5 evicts tag 1
    do_access(1'b0, 8'h02, '0);  // R5 tag 0 still present
    do_access(1'b1, 8'h22, 32'hDEAD_BEEF);  // R6 write hit
    do_access(1'b0, 8'h22, '0);  // R6 readback
    do_access(1'b0, 8'h30, '0);  // evicts tag 0 (clean, R8)
    do_access(1'b0, 8'h40, '0);  // R7 evicts dirty tag 2
    do_access(1'b1, 8'h57, 32'h1234_5678);  // R9 write miss in set 1
    do_access(1'b0, 8'h56, '0);
    do_access(1'b0, 8'h57, '0);  // R9 word written
    do_access(1'b0, 8'h65, '0);
    do_access(1'b0, 8'h75, '0);  // R7 evicts dirty tag 5
    do_access(1'b0, 8'h04, '0);  // R1 other sets independent
    do_access(1'b0, 8'h08, '0);
    do_access(1'b0, 8'h0C, '0);
    // random mix over few tags to force conflicts
    for (int k = 0; k < 400; k++) begin
      logic [7:0] ra;
      ra = {2'b00, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      do_access(1'($urandom_range(0, 1)), ra, $urandom);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule